// File: doc/BRIEF.md
# DMA Bus Bandwidth Throttle

This block sits between the read/write sequencer of a DMA engine and the request line toward the system bus. It inserts idle cycles after completed bus accesses, so the engine takes a smaller share of the bus. A 2-bit control code selects the throttle. It can be off, or it can insert a short pause or a long pause. Code 01 has no defined meaning and is handled as described below. The code is captured when a minor loop starts and stays fixed until the next minor loop starts.

Start-up latency stays low because the throttle does not act on the first completions of a minor loop. It also does not pause after the access that is flagged as the last write of the minor loop. The sequencer must not raise its next bus request while `stall_o` is high. The stall length, the number of exempt leading completions and the handling of code 01 are parameters.

Top module: `dma_bw_throttle`

## Requirements
- R1: After reset, `stall_o` and `rsvd_seen_o` are low. Until the first minor-loop start, completions cause no stall.
- R2: With code 00 held for the loop, no completion ever raises `stall_o`.
- R3: With code 10 held, a completion that is not exempt drives `stall_o` high for exactly SHORT_LEN cycles (default 4). The stall starts in the cycle after the clock edge at which the completion was sampled.
- R4: With code 11 held, a completion that is not exempt drives `stall_o` high for exactly LONG_LEN cycles (default 8), with the same timing as R3.
- R5: Code 01 sampled at a loop start causes no stalls in that loop. It sets `rsvd_seen_o` in the next cycle, and `rsvd_seen_o` stays high until reset.
- R6: The first LEAD_SKIP completions (default 2) after each loop start never cause a stall.
- R7: A completion sampled with `acc_last_i` high causes no stall.
- R8: Changes on `bwc_code_i` between loop starts have no effect on stalling.
- R9: A loop start ends any stall in the next cycle. A completion sampled in the same cycle as a loop start is ignored and is not counted toward R6.
- R10: A completion that is not exempt, sampled while a stall is running, reloads the stall to its full length.
- R11: `stall_o` only rises in the cycle after a sampled completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bwc_code_i | input | 2 | Throttle code: 00 off, 01 undefined, 10 short, 11 long |
| loop_start_i | input | 1 | One-cycle pulse at the start of a minor loop |
| acc_done_i | input | 1 | One-cycle strobe: a read or write access completed |
| acc_last_i | input | 1 | Qualifies `acc_done_i`: this is the last write of the minor loop |
| stall_o | output | 1 | High while the next bus request must be held off |
| rsvd_seen_o | output | 1 | Sticky flag: code 01 was captured at a loop start |

## Verification
The hardest states to reach from the ports are a completion that arrives while a stall is still running, and a loop start that collides with a completion or cuts a long stall short. The stimulus reaches them by driving completions at controlled gaps inside a stall window and by timing loop starts in the middle of a stall. In the same loops it also changes `bwc_code_i` so that a wrongly re-sampled code would show up. A behavioural reference model checks `stall_o` and `rsvd_seen_o` on every clock, so timing errors of one cycle are detected.

// File: rtl/dma_bwt_pkg.sv
package dma_bwt_pkg;

   typedef enum logic [1:0] {
      BWC_OFF   = 2'b00,
      BWC_UNDEF = 2'b01,
      BWC_SHORT = 2'b10,
      BWC_LONG  = 2'b11
   } bwc_e;

   // width needed to hold the value n (at least one bit)
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/bwt_code_latch.sv
module bwt_code_latch
   import dma_bwt_pkg::*;
#(
   parameter int unsigned SHORT_LEN    = 4,
   parameter int unsigned LONG_LEN     = 8,
   parameter bit          UNDEF_IS_OFF = 1'b1,
   localparam int unsigned CW          = cnt_width(LONG_LEN)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          loop_start_i,
   input  logic [1:0]    code_i,
   output logic [CW-1:0] len_o,
   output logic          rsvd_seen_o
);

   localparam logic [CW-1:0] ShortLen = CW'(SHORT_LEN);
   localparam logic [CW-1:0] LongLen  = CW'(LONG_LEN);

   bwc_e          code_e;
   logic [CW-1:0] len_dec;
   logic [CW-1:0] len_q;
   logic          rsvd_q;

   assign code_e = bwc_e'(code_i);

   // decode of the undefined code is selected at elaboration
   generate
      if (UNDEF_IS_OFF) begin : g_undef_off
         always_comb begin
            unique case (code_e)
               BWC_SHORT: len_dec = ShortLen;
               BWC_LONG:  len_dec = LongLen;
               default:   len_dec = '0;
            endcase
         end
      end else begin : g_undef_long
         always_comb begin
            unique case (code_e)
               BWC_OFF:   len_dec = '0;
               BWC_SHORT: len_dec = ShortLen;
               default:   len_dec = LongLen;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         len_q  <= '0;
         rsvd_q <= 1'b0;
      end else if (loop_start_i) begin
         len_q <= len_dec;
         if (code_e == BWC_UNDEF) rsvd_q <= 1'b1;
      end
   end

   assign len_o       = len_q;
   assign rsvd_seen_o = rsvd_q;

endmodule

// File: rtl/bwt_lead_window.sv
module bwt_lead_window
   import dma_bwt_pkg::*;
#(
   parameter int unsigned LEAD_SKIP = 2,
   localparam int unsigned LW       = cnt_width(LEAD_SKIP)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic loop_start_i,
   input  logic acc_done_i,
   output logic in_lead_o
);

   generate
      if (LEAD_SKIP == 0) begin : g_no_lead
         assign in_lead_o = 1'b0;
      end else begin : g_lead_cnt
         localparam logic [LW-1:0] Skip = LW'(LEAD_SKIP);
         logic [LW-1:0] seen_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               seen_q <= '0;
            end else if (loop_start_i) begin
               seen_q <= '0;
            end else if (acc_done_i && (seen_q < Skip)) begin
               seen_q <= seen_q + LW'(1);
            end
         end

         assign in_lead_o = (seen_q < Skip);
      end
   endgenerate

endmodule

// File: rtl/bwt_stall_timer.sv
module bwt_stall_timer #(
   parameter int unsigned CW = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clear_i,
   input  logic          load_i,
   input  logic [CW-1:0] len_i,
   output logic          stall_o
);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         left_q <= '0;
      end else if (clear_i) begin
         left_q <= '0;
      end else if (load_i) begin
         left_q <= len_i;
      end else if (left_q != '0) begin
         left_q <= left_q - CW'(1);
      end
   end

   assign stall_o = (left_q != '0);

endmodule

// File: rtl/dma_bw_throttle.sv
module dma_bw_throttle
   import dma_bwt_pkg::*;
#(
   parameter int unsigned SHORT_LEN    = 4,
   parameter int unsigned LONG_LEN     = 8,
   parameter int unsigned LEAD_SKIP    = 2,
   parameter bit          UNDEF_IS_OFF = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] bwc_code_i,
   input  logic       loop_start_i,
   input  logic       acc_done_i,
   input  logic       acc_last_i,
   output logic       stall_o,
   output logic       rsvd_seen_o
);

   localparam int unsigned CW = cnt_width(LONG_LEN);

   generate
      if (SHORT_LEN < 1) begin : g_bad_short
         $error("SHORT_LEN must be at least 1");
      end
      if (LONG_LEN < SHORT_LEN) begin : g_bad_long
         $error("LONG_LEN must not be below SHORT_LEN");
      end
   endgenerate

   logic [CW-1:0] held_len;
   logic          in_lead;
   logic          load;

   bwt_code_latch #(
      .SHORT_LEN   (SHORT_LEN),
      .LONG_LEN    (LONG_LEN),
      .UNDEF_IS_OFF(UNDEF_IS_OFF)
   ) u_code (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .loop_start_i(loop_start_i),
      .code_i      (bwc_code_i),
      .len_o       (held_len),
      .rsvd_seen_o (rsvd_seen_o)
   );

   bwt_lead_window #(
      .LEAD_SKIP(LEAD_SKIP)
   ) u_lead (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .loop_start_i(loop_start_i),
      .acc_done_i  (acc_done_i),
      .in_lead_o   (in_lead)
   );

   assign load = acc_done_i && !loop_start_i && !in_lead && !acc_last_i
              && (held_len != '0);

   bwt_stall_timer #(
      .CW(CW)
   ) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(loop_start_i),
      .load_i (load),
      .len_i  (held_len),
      .stall_o(stall_o)
   );

endmodule

// File: rtl/dma_bw_throttle_chk.sv
module dma_bw_throttle_chk #(
   parameter int unsigned LONG_LEN  = 8,
   parameter int unsigned LEAD_SKIP = 2
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] bwc_code_i,
   input logic       loop_start_i,
   input logic       acc_done_i,
   input logic       acc_last_i,
   input logic       stall_o,
   input logic       rsvd_seen_o
);

   int unsigned since_done;
   int unsigned lead_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         since_done <= LONG_LEN + 1;
         lead_cnt   <= 0;
      end else begin
         if (acc_done_i) since_done <= 1;
         else if (since_done <= LONG_LEN) since_done <= since_done + 1;
         if (loop_start_i) lead_cnt <= 0;
         else if (acc_done_i && lead_cnt < LEAD_SKIP) lead_cnt <= lead_cnt + 1;
      end
   end

   AST_RSVD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (loop_start_i && bwc_code_i == 2'b01) |=> rsvd_seen_o); // R5
   AST_RSVD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsvd_seen_o |=> rsvd_seen_o); // R5
   AST_LEAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_done_i && !loop_start_i && lead_cnt < LEAD_SKIP && !stall_o) |=> !stall_o); // R6
   AST_LAST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_done_i && acc_last_i && !stall_o) |=> !stall_o); // R7
   AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      loop_start_i |=> !stall_o); // R9
   AST_STALL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o |-> since_done <= LONG_LEN); // R4
   AST_RISE_CAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stall_o) |-> $past(acc_done_i)); // R11

endmodule

bind dma_bw_throttle dma_bw_throttle_chk #(
   .LONG_LEN (LONG_LEN),
   .LEAD_SKIP(LEAD_SKIP)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bwc_code_i  (bwc_code_i),
   .loop_start_i(loop_start_i),
   .acc_done_i  (acc_done_i),
   .acc_last_i  (acc_last_i),
   .stall_o     (stall_o),
   .rsvd_seen_o (rsvd_seen_o)
);

// File: tb/test_dma_bw_throttle.sv
module test_dma_bw_throttle;

   localparam int PERIOD = 10;
   localparam int SHORT  = 4;
   localparam int LONG   = 8;
   localparam int SKIP   = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] code = 2'b00;
   logic       start = 1'b0;
   logic       done = 1'b0;
   logic       last = 1'b0;
   logic       stall;
   logic       rsvd;

   int    vectors = 0;
   int    miscompares = 0;
   string tag = "R1";
   bit    finished = 1'b0;

   // reference state
   int m_len = 0;
   int m_seen = 0;
   int m_left = 0;
   bit m_rsvd = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   dma_bw_throttle i_dma_bw_throttle (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bwc_code_i  (code),
      .loop_start_i(start),
      .acc_done_i  (done),
      .acc_last_i  (last),
      .stall_o     (stall),
      .rsvd_seen_o (rsvd)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_len = 0; m_seen = 0; m_left = 0; m_rsvd = 1'b0;
      end else if (start) begin
         m_len  = (code == 2'b10) ? SHORT : (code == 2'b11) ? LONG : 0;
         if (code == 2'b01) m_rsvd = 1'b1;
         m_seen = 0;
         m_left = 0;
      end else begin
         if (m_left > 0) m_left = m_left - 1;
         if (done) begin
            if (m_seen >= SKIP && !last && m_len != 0) m_left = m_len;
            if (m_seen < SKIP) m_seen = m_seen + 1;
         end
      end
      #(PERIOD/4);
      if (!finished) begin
         vectors++;
         if (stall !== (m_left != 0)) begin
            miscompares++;
            $display("FAIL %s stall actual=%b expected=%b at %0t", tag, stall, (m_left != 0), $time);
         end
         if (rsvd !== m_rsvd) begin
            miscompares++;
            $display("FAIL %s rsvd_seen actual=%b expected=%b at %0t", tag, rsvd, m_rsvd, $time);
         end
      end
   end

   task automatic cyc(input bit s, input bit d, input bit l);
      @(negedge clk);
      start = s; done = d; last = l;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0);
   endtask

   task automatic loop_run(input logic [1:0] c, input int accs, input int gap);
      @(negedge clk);
      code = c;
      cyc(1, 0, 0);
      for (int i = 0; i < accs; i++) begin
         cyc(0, 1, (i == accs - 1));
         idle(gap);
      end
   endtask

   initial begin
      #(PERIOD * 50000);
      miscompares++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      // R1: reset state and completions before any loop start
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      code = 2'b11;
      cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0); idle(10);

      tag = "R2"; loop_run(2'b00, 6, 3); idle(4);
      tag = "R3"; loop_run(2'b10, 6, 6); idle(4);
      tag = "R4"; loop_run(2'b11, 6, 10); idle(4);
      tag = "R6"; loop_run(2'b11, 2, 12); idle(4);   // only lead accesses
      tag = "R7"; loop_run(2'b10, 3, 8); idle(4);    // third is last
      tag = "R5"; loop_run(2'b01, 6, 2); idle(4);
      tag = "R5"; loop_run(2'b10, 5, 5); idle(4);    // sticky flag persists

      // R8: code changes mid-loop are ignored
      tag = "R8";
      @(negedge clk); code = 2'b10; cyc(1, 0, 0);
      cyc(0, 1, 0); cyc(0, 1, 0);
      @(negedge clk); code = 2'b11;
      cyc(0, 1, 0); idle(12);
      @(negedge clk); code = 2'b00;
      cyc(0, 1, 0); idle(12);

      // R10: completions inside a running stall reload it
      tag = "R10";
      @(negedge clk); code = 2'b11; cyc(1, 0, 0);
      cyc(0, 1, 0); cyc(0, 1, 0);
      cyc(0, 1, 0); idle(3); cyc(0, 1, 0); idle(6); cyc(0, 1, 0); idle(12);

      // R9: loop start cuts stall; coincident completion ignored
      tag = "R9";
      @(negedge clk); code = 2'b11; cyc(1, 0, 0);
      cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0); idle(3);
      cyc(1, 1, 0);                 // restart, completion dropped
      cyc(0, 1, 0); cyc(0, 1, 0);   // still lead
      cyc(0, 1, 0); idle(10);

      // R11: back-to-back completions with short code
      tag = "R11";
      loop_run(2'b10, 8, 1); idle(8);
      loop_run(2'b11, 5, 0); idle(12);

      // R1: reset again mid-stall clears everything
      tag = "R1";
      @(negedge clk); code = 2'b11; cyc(1, 0, 0);
      cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0); idle(2);
      @(negedge clk); rst_n = 1'b0; idle(2);
      @(negedge clk); rst_n = 1'b1; idle(4);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule